// File: doc/BRIEF.md
# BCD Time-of-Day Calendar with Alarm

This core keeps wall-clock time for a larger chip. Seconds, minutes and hours are held in packed BCD, and the date is a plain binary count of days. A one-cycle tick enable, produced elsewhere once per second, advances the time when the run bit is set. Software reaches the calendar through a byte-wide register file. The register file holds the running time, an alarm setting and a control byte.

The alarm has no seconds field. It compares minutes, hours and the day count, and each of the three comparisons has its own enable. When the time first reaches the enabled alarm fields, a sticky flag is set. The interrupt output is that flag gated by an interrupt enable. Software clears the flag by writing one to its bit.

Software writes to the time registers take effect at once. A write that arrives in the same cycle as a tick is held for one cycle and then applied. A busy bit in the control byte shows that cycle.

Top module: `tod_calendar`

## Requirements
- R1: After reset, every mapped register reads 0x00 and `alarm_irq` is low.
- R2: Seconds count in BCD from 0x00 to 0x59. A nine in the ones digit carries into the tens digit. The count advances only on a tick while control bit 0 (run) is 1, and holds when run is 0.
- R3: A seconds rollover from 0x59 to 0x00 advances the minutes. A minutes rollover from 0x59 to 0x00 advances the hours (BCD, 24-hour form, 0x00 to 0x23).
- R4: An hours rollover from 0x23 to 0x00 increments a 16-bit binary day count. The low byte of the day count is at offset 0x18 and the high byte is at offset 0x19.
- R5: The day count wraps from 0xFFFF to 0x0000.
- R6: The register window starts at byte address 0x14:
  - 0x14 is the control byte.
  - 0x15, 0x16 and 0x17 are seconds, minutes and hours.
  - 0x18 and 0x19 are the day count, low byte then high byte.
  - 0x1A and 0x1B are the alarm minutes and alarm hours.
  - 0x1C and 0x1D are the alarm day, low byte then high byte.

  Addresses outside 0x14 to 0x1D read 0x00, and writes to them have no effect. Control bit 6 always reads 0.
- R7: A write to a time or alarm register is visible on a read in the cycle after the write.
- R8: Control bit 7 (busy) reads 1 in the cycle in which a tick advances the running calendar, and reads 0 in every other cycle. A write presented in a busy cycle is applied one cycle later, after the advance.
- R9: Control bits 3, 4 and 5 enable the minute, hour and day comparisons. Control bit 2 (alarm flag) is set on a tick whose new time matches every enabled field while the old time did not. With no comparison enabled, the flag is never set.
- R10: Writing 1 to control bit 2 clears the alarm flag. Writing 0 to bit 2 leaves the flag unchanged.
- R11: `alarm_irq` is high exactly when the alarm flag is set and control bit 1 (interrupt enable) is 1.
- R12: Seconds take no part in the alarm. After the flag is cleared, further ticks within the same matching minute do not set it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1s | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | ADDR_W | Register read byte address |
| rd_data | output | 8 | Register read data (combinational) |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
The assertions assume two things about the inputs:
- Every tick pulse is followed by at least one idle cycle, so at most one write is ever waiting behind a busy cycle.
- Software writes only well-formed BCD values within range to seconds, minutes and hours.

The bench issues every tick through a task that always leaves one idle cycle after the pulse. Every time value it writes is a legal BCD value. The single write placed on a busy cycle is followed directly by an idle cycle.

// File: rtl/tod_cal_pkg.sv
`timescale 1ns/1ps
package tod_cal_pkg;

    localparam int BYTE_W   = 8;
    localparam int DAY_W    = 16;
    localparam int NUM_REGS = 10;
    localparam int OFS_W    = 4;

    // control byte bit positions
    localparam int CB_RUN  = 0;
    localparam int CB_AIE  = 1;
    localparam int CB_FLAG = 2;
    localparam int CB_MEN  = 3;
    localparam int CB_HEN  = 4;
    localparam int CB_DEN  = 5;
    localparam int CB_BUSY = 7;

    localparam logic [BYTE_W-1:0] SEC_LIM  = 8'h59;
    localparam logic [BYTE_W-1:0] MIN_LIM  = 8'h59;
    localparam logic [BYTE_W-1:0] HOUR_LIM = 8'h23;

    typedef enum logic [OFS_W-1:0] {
        OFS_CTRL  = 4'd0,
        OFS_SEC   = 4'd1,
        OFS_MIN   = 4'd2,
        OFS_HOUR  = 4'd3,
        OFS_DAYL  = 4'd4,
        OFS_DAYH  = 4'd5,
        OFS_AMIN  = 4'd6,
        OFS_AHOUR = 4'd7,
        OFS_ADAYL = 4'd8,
        OFS_ADAYH = 4'd9
    } reg_ofs_e;

    typedef struct packed {
        logic [DAY_W-1:0]  day;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] sec;
    } tod_t;

    typedef struct packed {
        logic [DAY_W-1:0]  day;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] min;
    } alm_t;

    typedef struct packed {
        logic den;
        logic hen;
        logic men;
        logic aie;
        logic run;
    } ctl_t;

    // one BCD step; bit 8 signals the wrap back to zero
    function automatic logic [BYTE_W:0] bcd_step(input logic [BYTE_W-1:0] v,
                                                 input logic [BYTE_W-1:0] lim);
        if (v == lim)
            return {1'b1, 8'h00};
        else if (v[3:0] == 4'd9)
            return {1'b0, v[7:4] + 4'd1, 4'd0};
        else
            return {1'b0, v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic tod_t tod_advance(input tod_t t);
        tod_t r;
        logic [BYTE_W:0] s;
        logic [BYTE_W:0] m;
        logic [BYTE_W:0] h;
        r = t;
        m = '0;
        h = '0;
        s = bcd_step(t.sec, SEC_LIM);
        r.sec = s[BYTE_W-1:0];
        if (s[BYTE_W]) begin
            m = bcd_step(t.min, MIN_LIM);
            r.min = m[BYTE_W-1:0];
            if (m[BYTE_W]) begin
                h = bcd_step(t.hour, HOUR_LIM);
                r.hour = h[BYTE_W-1:0];
                if (h[BYTE_W])
                    r.day = t.day + 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/tod_wr_gate.sv
`timescale 1ns/1ps
module tod_wr_gate
    import tod_cal_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              ap_en,
    output logic [ADDR_W-1:0] ap_addr,
    output logic [BYTE_W-1:0] ap_data
);

    logic              pend_v;
    logic [ADDR_W-1:0] pend_a;
    logic [BYTE_W-1:0] pend_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v <= 1'b0;
            pend_a <= '0;
            pend_d <= '0;
        end else if (busy || pend_v) begin
            // hold the incoming write behind the advance or the older one
            pend_v <= wr_en;
            pend_a <= wr_addr;
            pend_d <= wr_data;
        end else begin
            pend_v <= 1'b0;
        end
    end

    always_comb begin
        ap_en   = !busy && (pend_v || wr_en);
        ap_addr = pend_v ? pend_a : wr_addr;
        ap_data = pend_v ? pend_d : wr_data;
    end

    assert_defer_R8: assert property (@(posedge clk) disable iff (rst)
        busy && wr_en |=> ap_en && ap_addr == $past(wr_addr) && ap_data == $past(wr_data));

    assert_tick_spacing_R8: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

endmodule

// File: rtl/tod_counter.sv
`timescale 1ns/1ps
module tod_counter
    import tod_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              wr_vld,
    input  logic [OFS_W-1:0]  wr_ofs,
    input  logic [BYTE_W-1:0] wr_dat,
    output tod_t              cur,
    output tod_t              nxt
);

    assign nxt = tod_advance(cur);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (adv) begin
            cur <= nxt;
        end else if (wr_vld) begin
            case (wr_ofs)
                OFS_SEC:  cur.sec          <= wr_dat;
                OFS_MIN:  cur.min          <= wr_dat;
                OFS_HOUR: cur.hour         <= wr_dat;
                OFS_DAYL: cur.day[7:0]     <= wr_dat;
                OFS_DAYH: cur.day[15:8]    <= wr_dat;
                default:  ;
            endcase
        end
    end

    assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        adv && cur.sec == SEC_LIM |=> cur.sec == 8'h00);

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !adv && !wr_vld |=> $stable(cur));

    assert_day_carry_R4: assert property (@(posedge clk) disable iff (rst)
        adv && cur.sec == SEC_LIM && cur.min == MIN_LIM && cur.hour == HOUR_LIM
        |=> cur.day == $past(cur.day) + 16'd1 && cur.hour == 8'h00);

    assert_no_write_in_adv_R8: assert property (@(posedge clk) disable iff (rst)
        adv |-> !wr_vld);

endmodule

// File: rtl/tod_alarm.sv
`timescale 1ns/1ps
module tod_alarm
    import tod_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  tod_t              cur,
    input  tod_t              nxt,
    input  logic              wr_vld,
    input  logic [OFS_W-1:0]  wr_ofs,
    input  logic [BYTE_W-1:0] wr_dat,
    output ctl_t              ctl,
    output logic              flag,
    output alm_t              alm,
    output logic              irq
);

    logic hit_now;
    logic hit_next;
    logic set_flag;
    logic clr_flag;

    function automatic logic fields_hit(input tod_t t, input alm_t a, input ctl_t c);
        return (c.men || c.hen || c.den)
            && (!c.men || t.min  == a.min)
            && (!c.hen || t.hour == a.hour)
            && (!c.den || t.day  == a.day);
    endfunction

    always_comb begin
        hit_now  = fields_hit(cur, alm, ctl);
        hit_next = fields_hit(nxt, alm, ctl);
        set_flag = adv && hit_next && !hit_now;
        clr_flag = wr_vld && (wr_ofs == OFS_CTRL) && wr_dat[CB_FLAG];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
            alm <= '0;
        end else if (wr_vld) begin
            case (wr_ofs)
                OFS_CTRL: begin
                    ctl.run <= wr_dat[CB_RUN];
                    ctl.aie <= wr_dat[CB_AIE];
                    ctl.men <= wr_dat[CB_MEN];
                    ctl.hen <= wr_dat[CB_HEN];
                    ctl.den <= wr_dat[CB_DEN];
                end
                OFS_AMIN:  alm.min       <= wr_dat;
                OFS_AHOUR: alm.hour      <= wr_dat;
                OFS_ADAYL: alm.day[7:0]  <= wr_dat;
                OFS_ADAYH: alm.day[15:8] <= wr_dat;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set_flag)
            flag <= 1'b1;
        else if (clr_flag)
            flag <= 1'b0;
    end

    assign irq = flag & ctl.aie;

    assert_flag_on_tick_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(adv));

    assert_w1c_R10: assert property (@(posedge clk) disable iff (rst)
        wr_vld && wr_ofs == OFS_CTRL && wr_dat[CB_FLAG] && !adv |=> !flag);

endmodule

// File: rtl/tod_calendar.sv
`timescale 1ns/1ps
module tod_calendar
    import tod_cal_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_BASE = 8'h14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1s,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              alarm_irq
);

    localparam logic [ADDR_W-1:0] WIN_SIZE = ADDR_W'(NUM_REGS);

    logic              busy;
    logic              ap_en;
    logic [ADDR_W-1:0] ap_addr;
    logic [BYTE_W-1:0] ap_data;
    logic [ADDR_W-1:0] ap_rel;
    logic [ADDR_W-1:0] rd_rel;
    logic              ap_hit;
    logic              rd_hit;
    logic              ap_vld;
    tod_t              cur;
    tod_t              nxt;
    ctl_t              ctl;
    alm_t              alm;
    logic              flag;
    logic [BYTE_W-1:0] ctrl_byte;

    assign busy = tick_1s & ctl.run;

    always_comb begin
        ap_rel = ap_addr - REG_BASE;
        rd_rel = rd_addr - REG_BASE;
        ap_hit = (ap_addr >= REG_BASE) && (ap_rel < WIN_SIZE);
        rd_hit = (rd_addr >= REG_BASE) && (rd_rel < WIN_SIZE);
        ap_vld = ap_en && ap_hit;
    end

    tod_wr_gate #(.ADDR_W(ADDR_W)) u_gate (
        .clk     (clk),
        .rst     (rst),
        .busy    (busy),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ap_en   (ap_en),
        .ap_addr (ap_addr),
        .ap_data (ap_data)
    );

    tod_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .adv    (busy),
        .wr_vld (ap_vld),
        .wr_ofs (ap_rel[OFS_W-1:0]),
        .wr_dat (ap_data),
        .cur    (cur),
        .nxt    (nxt)
    );

    tod_alarm u_alm (
        .clk    (clk),
        .rst    (rst),
        .adv    (busy),
        .cur    (cur),
        .nxt    (nxt),
        .wr_vld (ap_vld),
        .wr_ofs (ap_rel[OFS_W-1:0]),
        .wr_dat (ap_data),
        .ctl    (ctl),
        .flag   (flag),
        .alm    (alm),
        .irq    (alarm_irq)
    );

    always_comb begin
        ctrl_byte          = '0;
        ctrl_byte[CB_RUN]  = ctl.run;
        ctrl_byte[CB_AIE]  = ctl.aie;
        ctrl_byte[CB_FLAG] = flag;
        ctrl_byte[CB_MEN]  = ctl.men;
        ctrl_byte[CB_HEN]  = ctl.hen;
        ctrl_byte[CB_DEN]  = ctl.den;
        ctrl_byte[CB_BUSY] = busy;
    end

    always_comb begin
        rd_data = '0;
        if (rd_hit) begin
            case (rd_rel[OFS_W-1:0])
                OFS_CTRL:  rd_data = ctrl_byte;
                OFS_SEC:   rd_data = cur.sec;
                OFS_MIN:   rd_data = cur.min;
                OFS_HOUR:  rd_data = cur.hour;
                OFS_DAYL:  rd_data = cur.day[7:0];
                OFS_DAYH:  rd_data = cur.day[15:8];
                OFS_AMIN:  rd_data = alm.min;
                OFS_AHOUR: rd_data = alm.hour;
                OFS_ADAYL: rd_data = alm.day[7:0];
                OFS_ADAYH: rd_data = alm.day[15:8];
                default:   rd_data = '0;
            endcase
        end
    end

endmodule

// File: tb/tod_calendar_bench.sv
`timescale 1ns/1ps
module tod_calendar_bench;

    localparam logic [7:0] A_CTRL  = 8'h14;
    localparam logic [7:0] A_SEC   = 8'h15;
    localparam logic [7:0] A_MIN   = 8'h16;
    localparam logic [7:0] A_HOUR  = 8'h17;
    localparam logic [7:0] A_DAYL  = 8'h18;
    localparam logic [7:0] A_DAYH  = 8'h19;
    localparam logic [7:0] A_AMIN  = 8'h1A;
    localparam logic [7:0] A_AHOUR = 8'h1B;
    localparam logic [7:0] A_ADAYL = 8'h1C;
    localparam logic [7:0] A_ADAYH = 8'h1D;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1s = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       alarm_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tod_calendar u_tod_calendar (
        .clk       (clk),
        .rst       (rst),
        .tick_1s   (tick_1s),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .alarm_irq (alarm_irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic tk();
        @(negedge clk);
        tick_1s = 1'b1;
        @(negedge clk);
        tick_1s = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] m,
                            input logic [7:0] s, input logic [15:0] day);
        wr(A_SEC, s);
        wr(A_MIN, m);
        wr(A_HOUR, h);
        wr(A_DAYL, day[7:0]);
        wr(A_DAYH, day[15:8]);
    endtask

    task automatic set_alarm(input logic [7:0] h, input logic [7:0] m, input logic [15:0] day);
        wr(A_AMIN, m);
        wr(A_AHOUR, h);
        wr(A_ADAYL, day[7:0]);
        wr(A_ADAYH, day[15:8]);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int i = 0; i < 10; i++) begin
            rd(A_CTRL + 8'(i), d);
            chk("R1 register zero after reset", {8'h0, d}, 16'h0);
        end
        chk("R1 irq low after reset", {15'h0, alarm_irq}, 16'h0);
    endtask

    task automatic t_stopped();
        logic [7:0] d;
        wr(A_SEC, 8'h10);
        rd(A_SEC, d);
        chk("R7 seconds write readback", {8'h0, d}, 16'h0010);
        tk();
        rd(A_SEC, d);
        chk("R2 no advance while stopped", {8'h0, d}, 16'h0010);
    endtask

    task automatic t_count();
        logic [7:0] d;
        wr(A_CTRL, 8'h01);
        wr(A_SEC, 8'h09);
        tk();
        rd(A_SEC, d);
        chk("R2 bcd ones carry", {8'h0, d}, 16'h0010);
        set_time(8'h05, 8'h59, 8'h58, 16'h0000);
        tk();
        rd(A_SEC, d);
        chk("R2 seconds to 59", {8'h0, d}, 16'h0059);
        tk();
        rd(A_SEC, d);
        chk("R3 seconds wrap", {8'h0, d}, 16'h0000);
        rd(A_MIN, d);
        chk("R3 minutes wrap", {8'h0, d}, 16'h0000);
        rd(A_HOUR, d);
        chk("R3 hours advance", {8'h0, d}, 16'h0006);
    endtask

    task automatic t_day();
        logic [7:0] d;
        set_time(8'h23, 8'h59, 8'h59, 16'h00FF);
        rd(A_DAYL, d);
        chk("R7 day low readback", {8'h0, d}, 16'h00FF);
        tk();
        rd(A_HOUR, d);
        chk("R4 hours wrap", {8'h0, d}, 16'h0000);
        rd(A_DAYL, d);
        chk("R4 day low byte", {8'h0, d}, 16'h0000);
        rd(A_DAYH, d);
        chk("R4 day high byte", {8'h0, d}, 16'h0001);
        set_time(8'h23, 8'h59, 8'h59, 16'hFFFF);
        tk();
        rd(A_DAYL, d);
        chk("R5 day wrap low", {8'h0, d}, 16'h0000);
        rd(A_DAYH, d);
        chk("R5 day wrap high", {8'h0, d}, 16'h0000);
    endtask

    task automatic t_map();
        logic [7:0] d;
        wr(A_CTRL, 8'h41);
        rd(A_CTRL, d);
        chk("R6 control bit 6 reads zero", {8'h0, d}, 16'h0001);
        wr(8'h20, 8'hAA);
        rd(8'h20, d);
        chk("R6 unmapped read above", {8'h0, d}, 16'h0000);
        wr(8'h13, 8'h55);
        rd(8'h13, d);
        chk("R6 unmapped read below", {8'h0, d}, 16'h0000);
        rd(A_CTRL, d);
        chk("R6 control untouched by unmapped write", {8'h0, d}, 16'h0001);
        wr(A_AHOUR, 8'h17);
        rd(A_AHOUR, d);
        chk("R7 alarm hour readback", {8'h0, d}, 16'h0017);
    endtask

    task automatic t_busy();
        logic [7:0] d;
        set_time(8'h01, 8'h02, 8'h03, 16'h0000);
        rd(A_CTRL, d);
        chk("R8 busy low when idle", {15'h0, d[7]}, 16'h0);
        @(negedge clk);
        tick_1s = 1'b1;
        wr_en = 1'b1; wr_addr = A_SEC; wr_data = 8'h30;
        rd(A_CTRL, d);
        chk("R8 busy high during advance", {15'h0, d[7]}, 16'h1);
        @(negedge clk);
        tick_1s = 1'b0;
        wr_en = 1'b0;
        rd(A_SEC, d);
        chk("R8 advance before deferred write", {8'h0, d}, 16'h0004);
        @(negedge clk);
        rd(A_SEC, d);
        chk("R8 deferred write applied", {8'h0, d}, 16'h0030);
    endtask

    task automatic t_alarm();
        logic [7:0] d;
        set_alarm(8'h10, 8'h05, 16'h0003);
        wr(A_CTRL, 8'h3B);
        set_time(8'h10, 8'h04, 8'h58, 16'h0003);
        tk();
        rd(A_CTRL, d);
        chk("R9 no flag before match", {8'h0, d}, 16'h003B);
        tk();
        rd(A_CTRL, d);
        chk("R9 flag on full match", {8'h0, d}, 16'h003F);
        chk("R11 irq with enable", {15'h0, alarm_irq}, 16'h1);
        wr(A_CTRL, 8'h3B);
        rd(A_CTRL, d);
        chk("R10 write zero keeps flag", {8'h0, d}, 16'h003F);
        wr(A_CTRL, 8'h3F);
        rd(A_CTRL, d);
        chk("R10 write one clears flag", {8'h0, d}, 16'h003B);
        chk("R11 irq drops with flag", {15'h0, alarm_irq}, 16'h0);
        tk();
        rd(A_CTRL, d);
        chk("R12 no re-set within same minute", {8'h0, d}, 16'h003B);
        rd(A_SEC, d);
        chk("R12 seconds still counting", {8'h0, d}, 16'h0001);
    endtask

    task automatic t_irq_gate();
        logic [7:0] d;
        wr(A_CTRL, 8'h39);
        set_time(8'h10, 8'h04, 8'h59, 16'h0003);
        tk();
        rd(A_CTRL, d);
        chk("R11 flag set with irq disabled", {8'h0, d}, 16'h003D);
        chk("R11 irq masked", {15'h0, alarm_irq}, 16'h0);
        wr(A_CTRL, 8'h3B);
        chk("R11 irq on enabling", {15'h0, alarm_irq}, 16'h1);
        wr(A_CTRL, 8'h3F);
    endtask

    task automatic t_partial();
        logic [7:0] d;
        set_alarm(8'h22, 8'h05, 16'h0077);
        wr(A_CTRL, 8'h09);
        set_time(8'h07, 8'h04, 8'h59, 16'h0009);
        tk();
        rd(A_CTRL, d);
        chk("R9 minute-only match", {8'h0, d}, 16'h000D);
        wr(A_CTRL, 8'h0D);
        wr(A_CTRL, 8'h01);
        set_time(8'h07, 8'h04, 8'h59, 16'h0009);
        tk();
        rd(A_CTRL, d);
        chk("R9 no enables never sets", {8'h0, d}, 16'h0001);
        wr(A_CTRL, 8'h11);
        set_time(8'h07, 8'h04, 8'h59, 16'h0009);
        tk();
        rd(A_CTRL, d);
        chk("R9 hour mismatch blocks flag", {8'h0, d}, 16'h0011);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_stopped();
        t_count();
        t_day();
        t_map();
        t_busy();
        t_alarm();
        t_irq_gate();
        t_partial();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule